// File: doc/BRIEF.md
# IPv4 Header Forwarding Editor

This block sits in a forwarding pipeline and edits an IPv4 header as it passes through. The header arrives as a stream of 16-bit words with a valid/ready handshake. The block decrements the time-to-live field. It can also replace the type-of-service byte with a new QoS marking. It then corrects the header checksum incrementally, using ones'-complement arithmetic, so the edited header is valid on the way out. The checksum is never summed over the whole header again.

The first six words of each header are held back in a small buffer. By the time the checksum word has arrived, both edits and the forwarding decision are known. The six held words are then emitted. Any remaining header words, as given by the length field, pass straight through. The next input word starts a new header.

Some headers cannot be forwarded: a time-to-live of 0 or 1, or a header length below the minimum. For these, an exception flag is raised and the header is passed out without any change.

Top module: `ipv4_fwd_upd`

## Requirements
- R1: Header word layout, in stream order from word 0. Word 0 holds version [15:12], header length in 32-bit units [11:8] and type-of-service [7:0]. Word 4 holds time-to-live [15:8] and protocol [7:0]. Word 5 is the header checksum. A header is 2×length words long, and the following word is word 0 of the next header.
- R2: For a forwarded header, output word 4 carries the time-to-live reduced by exactly one, with the protocol byte unchanged.
- R3: When `tos_wr_en_i` is 1 in the cycle word 0 is accepted, output word 0 carries `tos_val_i` (sampled in that same cycle) as its type-of-service byte. Otherwise word 0 is unchanged. The value of these inputs during any other word has no effect.
- R4: For a forwarded header, output word 5 equals the ones' complement of the ones'-complement (end-around carry) sum of all other output header words.
- R5: A header whose time-to-live is 0 or 1 is emitted with every word unchanged, and `exc_o` is raised.
- R6: A header whose length field is below 5 is treated as 10 words long, emitted unchanged, and `exc_o` is raised.
- R7: Header words from word 6 up to the last word pass through unchanged.
- R8: Every accepted word is emitted exactly once, in order. While `out_valid_o` is high and `out_ready_i` is low, the output word stays stable.
- R9: After reset, `out_valid_o` and `exc_o` are 0 and `in_ready_o` is 1.
- R10: `exc_o` is 1 with every output word of an exception header, and 0 with every output word of a forwarded header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | 16 | Incoming header word |
| in_valid_i | input | 1 | Incoming word valid |
| in_ready_o | output | 1 | Block can accept a word |
| tos_wr_en_i | input | 1 | Replace type-of-service, sampled with word 0 |
| tos_val_i | input | 8 | New type-of-service value |
| out_data_o | output | 16 | Outgoing header word |
| out_valid_o | output | 1 | Outgoing word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| exc_o | output | 1 | Current header is not forwarded |

## Verification
The test headers include:
- plain forwarding with no TOS change, and a TOS rewrite;
- time-to-live exactly 2, which is still forwarded;
- time-to-live 1 and 0, which are exceptions;
- a length field of 4;
- option-bearing lengths of 6, 7 and the maximum, 15.

Together these separate the forward decision from the exception decision, and show the checksum correction with one edit and with two. They also mark where the held section ends and pass-through begins. The enable and value for the TOS rewrite are flipped on every word except word 0, which shows that only word 0's sample counts. The input has gaps and the output has periodic backpressure, which catches words that are lost, repeated or unstable.

// File: rtl/ipv4_upd_pkg.sv
package ipv4_upd_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned HOLD_WORDS = 6;   // words 0..5 up to and including checksum
  localparam int unsigned LEN_W      = 4;
  localparam int unsigned MIN_LEN    = 5;
  localparam int unsigned MAX_WORDS  = 2 * ((1 << LEN_W) - 1);
  localparam int unsigned CNT_W      = $clog2(MAX_WORDS + 1);
  localparam int unsigned TOS_IDX    = 0;
  localparam int unsigned TTL_IDX    = 4;
  localparam int unsigned CSUM_IDX   = 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_EMIT    = 2'd1,
    ST_PASS    = 2'd2
  } upd_state_e;

  function automatic word_t oc_add(input word_t a, input word_t b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[WORD_W-1:0] + word_t'(s[WORD_W]);
  endfunction

  // incremental update: new = ~(~old + ~m + m')
  function automatic word_t csum_patch(input word_t old_c, input word_t m_old, input word_t m_new);
    return ~oc_add(oc_add(~old_c, ~m_old), m_new);
  endfunction
endpackage

// File: rtl/hdr_hold_buf.sv
module hdr_hold_buf
  import ipv4_upd_pkg::*;
#(
  parameter int unsigned DEPTH = HOLD_WORDS,
  parameter int unsigned IDX_W = CNT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  word_t                  wr_data_i,
  output word_t [DEPTH-1:0]      held_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    word_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      slot_q <= '0;
      else if (wr_i && (wr_idx_i == IDX_W'(g)))         slot_q <= wr_data_i;
    end
    assign held_o[g] = slot_q;
  end
endmodule

// File: rtl/hdr_edit.sv
module hdr_edit
  import ipv4_upd_pkg::*;
#(
  parameter int unsigned DEPTH = HOLD_WORDS
) (
  input  word_t [DEPTH-1:0]  held_i,
  input  logic               tos_en_i,
  input  logic [BYTE_W-1:0]  tos_val_i,
  output word_t [DEPTH-1:0]  edited_o,
  output logic               exc_o
);
  logic [LEN_W-1:0]  len_f;
  logic [BYTE_W-1:0] ttl_f;
  word_t             w_tos_new, w_ttl_new, csum_a, csum_b;

  assign len_f = held_i[TOS_IDX][11:8];
  assign ttl_f = held_i[TTL_IDX][15:8];
  assign exc_o = (len_f < LEN_W'(MIN_LEN)) || (ttl_f < 8'd2);

  assign w_tos_new = tos_en_i ? {held_i[TOS_IDX][15:8], tos_val_i} : held_i[TOS_IDX];
  assign w_ttl_new = {ttl_f - 8'd1, held_i[TTL_IDX][7:0]};

  assign csum_a = csum_patch(held_i[CSUM_IDX], held_i[TTL_IDX], w_ttl_new);
  assign csum_b = tos_en_i ? csum_patch(csum_a, held_i[TOS_IDX], w_tos_new) : csum_a;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    if (g == TOS_IDX) begin : g_tos
      assign edited_o[g] = exc_o ? held_i[g] : w_tos_new;
    end else if (g == TTL_IDX) begin : g_ttl
      assign edited_o[g] = exc_o ? held_i[g] : w_ttl_new;
    end else if (g == CSUM_IDX) begin : g_csum
      assign edited_o[g] = exc_o ? held_i[g] : csum_b;
    end else begin : g_keep
      assign edited_o[g] = held_i[g];
    end
  end
endmodule

// File: rtl/ipv4_fwd_upd.sv
module ipv4_fwd_upd
  import ipv4_upd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] in_data_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic        tos_wr_en_i,
  input  logic [7:0]  tos_val_i,
  output logic [15:0] out_data_o,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic        exc_o
);
  upd_state_e            state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  tos_en_q;
  logic [BYTE_W-1:0]     tos_val_q;
  word_t [HOLD_WORDS-1:0] held;
  word_t [HOLD_WORDS-1:0] edited;
  logic                  hdr_exc;
  logic                  in_fire, out_fire, collect_st, emit_st, pass_st;
  logic [CNT_W-1:0]      hdr_words, emit_idx;
  logic [LEN_W-1:0]      len_f;

  assign collect_st = (state_q == ST_COLLECT);
  assign emit_st    = (state_q == ST_EMIT);
  assign pass_st    = (state_q == ST_PASS);

  hdr_hold_buf #(.DEPTH(HOLD_WORDS), .IDX_W(CNT_W)) i_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (collect_st && in_valid_i),
    .wr_idx_i  (cnt_q),
    .wr_data_i (in_data_i),
    .held_o    (held)
  );

  hdr_edit #(.DEPTH(HOLD_WORDS)) i_edit (
    .held_i    (held),
    .tos_en_i  (tos_en_q),
    .tos_val_i (tos_val_q),
    .edited_o  (edited),
    .exc_o     (hdr_exc)
  );

  assign len_f     = held[TOS_IDX][11:8];
  assign hdr_words = (len_f < LEN_W'(MIN_LEN)) ? CNT_W'(2 * MIN_LEN) : {len_f, 1'b0};
  assign emit_idx  = (cnt_q < CNT_W'(HOLD_WORDS)) ? cnt_q : '0;

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = '0;
    unique case (state_q)
      ST_COLLECT: in_ready_o = 1'b1;
      ST_EMIT: begin
        out_valid_o = 1'b1;
        out_data_o  = edited[emit_idx];
      end
      ST_PASS: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
      end
      default: ;
    endcase
  end

  assign in_fire  = in_valid_i && in_ready_o;
  assign out_fire = out_valid_o && out_ready_i;
  assign exc_o    = hdr_exc && !collect_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_COLLECT;
      cnt_q     <= '0;
      tos_en_q  <= 1'b0;
      tos_val_q <= '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (in_fire) begin
          if (cnt_q == '0) begin
            tos_en_q  <= tos_wr_en_i;
            tos_val_q <= tos_val_i;
          end
          if (cnt_q == CNT_W'(HOLD_WORDS - 1)) begin
            state_q <= ST_EMIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_EMIT: if (out_fire) begin
          if (cnt_q == CNT_W'(HOLD_WORDS - 1)) begin
            if (hdr_words > CNT_W'(HOLD_WORDS)) begin
              state_q <= ST_PASS;
              cnt_q   <= CNT_W'(HOLD_WORDS);
            end else begin
              state_q <= ST_COLLECT;
              cnt_q   <= '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PASS: if (out_fire) begin
          if (cnt_q == hdr_words - 1'b1) begin
            state_q <= ST_COLLECT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_COLLECT;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  logic unused_pass;
  assign unused_pass = pass_st;
endmodule

// File: rtl/ipv4_fwd_upd_chk.sv
module ipv4_fwd_upd_chk
  import ipv4_upd_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [15:0]            out_data_o,
  input logic                   out_valid_o,
  input logic                   out_ready_i,
  input logic                   in_ready_o,
  input logic                   exc_o,
  input logic                   emit_i,
  input logic [CNT_W-1:0]       idx_i,
  input word_t [HOLD_WORDS-1:0] held_i
);
  a_r8_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r10_exc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(exc_o));

  a_r8_no_take_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |-> !in_ready_o);

  a_r2_ttl_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i && idx_i == CNT_W'(TTL_IDX) && !exc_o |->
      out_data_o[15:8] == held_i[TTL_IDX][15:8] - 8'd1);

  a_r5_ttl_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i && held_i[TTL_IDX][15:8] < 8'd2 |-> exc_o);

  a_r6_len_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i && held_i[TOS_IDX][11:8] < 4'd5 |-> exc_o);

  a_r5_csum_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i && exc_o && idx_i == CNT_W'(CSUM_IDX) |-> out_data_o == held_i[CSUM_IDX]);
endmodule

bind ipv4_fwd_upd ipv4_fwd_upd_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .in_ready_o  (in_ready_o),
  .exc_o       (exc_o),
  .emit_i      (emit_st),
  .idx_i       (cnt_q),
  .held_i      (held)
);

// File: tb/test_ipv4_fwd_upd.sv
`timescale 1ns/1ps
module test_ipv4_fwd_upd;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic        tos_wr_en_i = 1'b0;
  logic [7:0]  tos_val_i = '0;
  logic [15:0] out_data_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic        exc_o;

  always #2.5 clk_i = ~clk_i;

  ipv4_fwd_upd i_ipv4_fwd_upd (.*);

  // vector: len(4) ttl(8) tos_en(1) tos_new(8) tos_old(8) proto(8)
  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {4'd5,  8'd64,  1'b0, 8'h00, 8'h00, 8'h06},
    {4'd5,  8'd64,  1'b1, 8'hB8, 8'h00, 8'h11},
    {4'd6,  8'd2,   1'b1, 8'h2E, 8'h2E, 8'h01},
    {4'd5,  8'd1,   1'b1, 8'hA0, 8'h10, 8'h06},
    {4'd5,  8'd0,   1'b0, 8'h00, 8'h00, 8'h11},
    {4'd4,  8'd40,  1'b1, 8'h55, 8'h00, 8'h06},
    {4'd15, 8'd255, 1'b1, 8'h00, 8'hFF, 8'h32},
    {4'd7,  8'd128, 1'b0, 8'h77, 8'h04, 8'h2F}
  };
  localparam int MAXW = 512;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] in_w [MAXW];
  logic        in_en [MAXW];
  logic [7:0]  in_tv [MAXW];
  logic [15:0] exp_w [MAXW];
  logic        exp_x [MAXW];
  int          exp_pos [MAXW];
  logic [15:0] rx_w [MAXW];
  logic        rx_x [MAXW];
  int n_in = 0, rx_n = 0;

  function automatic logic [15:0] fold_sum(input logic [31:0] acc);
    logic [31:0] s;
    s = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return s[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build();
    for (int v = 0; v < NV; v++) begin
      logic [3:0] len; logic [7:0] ttl, tnew, told, proto; logic en, x;
      logic [15:0] w [30];
      logic [31:0] acc;
      int nw;
      {len, ttl, en, tnew, told, proto} = VEC[v];
      nw = (len < 5) ? 10 : 2 * len;
      for (int k = 0; k < nw; k++) w[k] = (16'hC0A8 ^ (16'(k) * 16'h00F1)) + 16'(v);
      w[0] = {4'h4, len, told};
      w[1] = 16'h0100 + 16'(v);
      w[3] = 16'h4000;
      w[4] = {ttl, proto};
      w[5] = 16'h0000;
      acc = 0;
      for (int k = 0; k < nw; k++) if (k != 5) acc += {16'd0, w[k]};
      w[5] = ~fold_sum(acc);
      x = (len < 5) || (ttl < 2);
      for (int k = 0; k < nw; k++) begin
        in_w[n_in + k] = w[k];
        // enable/value flipped away from word 0 (R3: only word 0 counts)
        in_en[n_in + k] = (k == 0) ? en : ~en;
        in_tv[n_in + k] = (k == 0) ? tnew : ~tnew;
      end
      if (!x) begin
        if (en) w[0] = {w[0][15:8], tnew};
        w[4] = {ttl - 8'd1, proto};
        acc = 0;
        for (int k = 0; k < nw; k++) if (k != 5) acc += {16'd0, w[k]};
        w[5] = ~fold_sum(acc);
      end
      for (int k = 0; k < nw; k++) begin
        exp_w[n_in + k] = w[k];
        exp_x[n_in + k] = x;
        exp_pos[n_in + k] = (len < 5) ? 100 + k : (ttl < 2) ? 200 + k : k;
      end
      n_in += nw;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    build();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check(out_valid_o == 1'b0, "R9 out_valid", 16'(out_valid_o), 16'd0);
    check(exc_o == 1'b0, "R9 exc", 16'(exc_o), 16'd0);
    check(in_ready_o == 1'b1, "R9 in_ready", 16'(in_ready_o), 16'd1);

    fork
      begin : drv
        for (int i = 0; i < n_in; i++) begin
          if (i % 7 == 3) begin
            @(negedge clk_i); in_valid_i = 1'b0;
          end
          @(negedge clk_i);
          in_valid_i = 1'b1; in_data_i = in_w[i];
          tos_wr_en_i = in_en[i]; tos_val_i = in_tv[i];
          #1;
          while (!in_ready_o) begin @(negedge clk_i); #1; end
        end
        @(negedge clk_i); in_valid_i = 1'b0;
      end
      begin : rcv
        int cyc = 0;
        while (rx_n < n_in) begin
          @(negedge clk_i);
          out_ready_i = (cyc % 4 != 1);
          cyc++;
          #1;
          if (out_valid_o && out_ready_i) begin
            rx_w[rx_n] = out_data_o; rx_x[rx_n] = exc_o; rx_n++;
          end
        end
        @(negedge clk_i); out_ready_i = 1'b1;
      end
    join

    for (int i = 0; i < n_in; i++) begin
      int p = exp_pos[i];
      string tag;
      if (p >= 200)      tag = "R5 unchanged";
      else if (p >= 100) tag = "R6 unchanged";
      else if (p == 0)   tag = "R3 tos word";
      else if (p == 4)   tag = "R2 ttl word";
      else if (p == 5)   tag = "R4 checksum";
      else if (p >= 6)   tag = "R7 passthrough";
      else               tag = "R1 word";
      check(rx_w[i] == exp_w[i], tag, rx_w[i], exp_w[i]);
      check(rx_x[i] == exp_x[i], "R10 exc flag", 16'(rx_x[i]), 16'(exp_x[i]));
    end

    repeat (4) @(negedge clk_i);
    #1;
    check(out_valid_o == 1'b0, "R8 no extra word", 16'(out_valid_o), 16'd0);
    check(rx_n == n_in, "R8 word count", 16'(rx_n), 16'(n_in));
    check(in_ready_o == 1'b1, "R1 ready for next header", 16'(in_ready_o), 16'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule